// File: doc/BRIEF.md
# Phase-Overlap PWM Generator

This block makes a pulse-width modulated signal without any counter-versus-threshold compare. Two phase accumulators step by the same frequency word on every clock. Each one gives a 50% square wave from its most significant bit. The second accumulator runs ahead of the first by a programmed phase offset. The two square waves are OR-combined, so the high time is one half period plus the offset. That alone covers duties from 50% to 100%. Below 50% the block uses the complementary offset and routes an inverted copy of the combined wave to the main pin, which gives full 0% to 100% coverage.

A second pin always carries the opposite level. On it, the combined wave is inverted one clock later through a register. When the duty command falls below one half, the main pin and the complement pin trade roles. Duty 0 and full-scale duty are decoded as steady levels. A change on either input reloads the phase relationship in the next cycle. After that the block keeps running with no further control activity.

Top module: `ovl_pwm_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, `pwm_o` is 0 and `pwm_n_o` is 1.
- R2: With a frequency word that is a power of two, `pwm_o` repeats every 2^ACC_W / `freq_i` clock cycles.
- R3: For a duty command D with 2^(DUTY_W-2) <= D < 2^(DUTY_W-1), `pwm_o` is high for exactly D·P/2^(DUTY_W-1) cycles of every carrier period P. The value 2^(DUTY_W-1) means 100%.
- R4: For 0 < D < 2^(DUTY_W-2), `pwm_o` is also high for exactly D·P/2^(DUTY_W-1) cycles per period. This range uses the inverted form of the combined wave.
- R5: D = 0 holds `pwm_o` at 0 and `pwm_n_o` at 1 with no pulses.
- R6: Any D >= 2^(DUTY_W-1) holds `pwm_o` at 1 and `pwm_n_o` at 0 with no pulses.
- R7: For D in the R3 range, `pwm_n_o` equals the inverse of the `pwm_o` value from one cycle earlier.
- R8: For D in the R4 range, the roles swap: `pwm_o` equals the inverse of the `pwm_n_o` value from one cycle earlier.
- R9: The carrier period depends only on `freq_i`. Two different duty commands at the same frequency word give the same period.
- R10: D = 2^(DUTY_W-2) (50%) gives a square wave that is high for exactly half of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_i | input | ACC_W | Phase increment added to both accumulators each cycle |
| duty_i | input | DUTY_W | Duty command; 2^(DUTY_W-1) is full scale |
| pwm_o | output | 1 | PWM output at the requested duty |
| pwm_n_o | output | 1 | Complement of `pwm_o` |

## Verification
The bench builds the block with ACC_W = 8 and DUTY_W = 5. With these values a full carrier period at unit frequency lasts only 256 cycles, and one duty step equals 1/16 of it. Every high-time count therefore comes out as an exact integer that can be compared over a whole period. These small values also let a single run cover both sides of the 50% swap, the two forced levels, a wrap of the duty field past full scale, and several carrier rates, all with short settling windows.

// File: rtl/ovl_pwm_pkg.sv
// Shared types for the phase-overlap PWM generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ovl_pwm_pkg;

    // Output routing chosen from the duty command
    typedef enum logic [1:0] {
        MODE_LOW    = 2'd0,   // steady low (0% duty)
        MODE_HIGH   = 2'd1,   // steady high (100% duty)
        MODE_DIRECT = 2'd2,   // OR wave on main pin, delayed inverse on complement
        MODE_INVERT = 2'd3    // delayed inverse on main pin, OR wave on complement
    } ovl_mode_e;

endpackage

// File: rtl/ovl_cfg.sv
// Duty/frequency decoder for the phase-overlap PWM generator.
// Spots a change on either command input and turns the duty command into a
// routing mode and a phase offset in accumulator units.
// Assumes: ACC_W >= DUTY_W and DUTY_W >= 3; full scale is 2^(DUTY_W-1).
module ovl_cfg
    import ovl_pwm_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  freq_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              reload_o,
    output logic [ACC_W-1:0]  inc_o,
    output logic [ACC_W-1:0]  off_o,
    output ovl_mode_e         mode_o
);

    localparam int FULL  = 1 << (DUTY_W - 1);
    localparam int HALF  = FULL >> 1;
    localparam int SHIFT = ACC_W - DUTY_W + 1;

    logic [ACC_W-1:0]  freq_q;
    logic [DUTY_W-1:0] duty_q;
    ovl_mode_e         mode_q;
    ovl_mode_e         mode_nxt;
    logic [DUTY_W-1:0] frac;

    // Detect a reprogramming event and select the increment in force this cycle
    always_comb begin
        reload_o = (freq_i != freq_q) || (duty_i != duty_q);
        inc_o    = reload_o ? freq_i : freq_q;
    end

    // Map the duty command onto a mode and an overlap fraction
    always_comb begin
        frac = '0;
        if (duty_i >= DUTY_W'(FULL)) begin
            mode_nxt = MODE_HIGH;
        end else if (duty_i == '0) begin
            mode_nxt = MODE_LOW;
        end else if (duty_i >= DUTY_W'(HALF)) begin
            mode_nxt = MODE_DIRECT;
            frac     = duty_i - DUTY_W'(HALF);
        end else begin
            mode_nxt = MODE_INVERT;
            frac     = DUTY_W'(HALF) - duty_i;
        end
        off_o = ACC_W'(frac) << SHIFT;
    end

    // Hold the programmed commands and the mode until the next change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
            duty_q <= '0;
            mode_q <= MODE_LOW;
        end else if (reload_o) begin
            freq_q <= freq_i;
            duty_q <= duty_i;
            mode_q <= mode_nxt;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/ovl_nco_pair.sv
// Two phase accumulators that share one increment. Accumulator 0 runs free.
// Accumulator 1 is reloaded to accumulator 0's next phase plus an offset
// whenever the configuration changes, then runs free.
// Assumes: load_i is a single-cycle strobe from the decoder.
module ovl_nco_pair #(
    parameter int ACC_W = 24,
    parameter int NCO_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_i,
    input  logic             load_i,
    input  logic [ACC_W-1:0] off_i,
    output logic [NCO_N-1:0] msb_o
);

    logic [ACC_W-1:0] acc [NCO_N];

    for (genvar g = 0; g < NCO_N; g++) begin : g_nco
        if (g == 0) begin : g_ref
            // Reference oscillator: plain phase accumulation
            always_ff @(posedge clk) begin
                if (!rst_n) acc[g] <= '0;
                else        acc[g] <= acc[g] + inc_i;
            end
        end else begin : g_lead
            // Leading oscillator: realign to the reference plus offset on reload
            always_ff @(posedge clk) begin
                if (!rst_n)      acc[g] <= '0;
                else if (load_i) acc[g] <= acc[0] + inc_i + off_i;
                else             acc[g] <= acc[g] + inc_i;
            end
        end
        assign msb_o[g] = acc[g][ACC_W-1];
    end

endmodule

// File: rtl/ovl_combine.sv
// Output stage: ORs the oscillator square waves, keeps a registered inverse,
// and routes the OR wave, its inverse or a steady level to the two pins.
// Assumes: mode_i is registered, so the outputs are free of decode glitches.
module ovl_combine
    import ovl_pwm_pkg::*;
#(
    parameter int NCO_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCO_N-1:0] msb_i,
    input  ovl_mode_e        mode_i,
    output logic             pwm_o,
    output logic             pwm_n_o
);

    logic wired_or;
    logic inv_q;

    assign wired_or = |msb_i;

    // Registered inverter: the inverse of the OR node, one cycle late
    always_ff @(posedge clk) begin
        if (!rst_n) inv_q <= 1'b1;
        else        inv_q <= ~wired_or;
    end

    // Pin routing; below 50% the true and complement roles trade places
    always_comb begin
        unique case (mode_i)
            MODE_HIGH:   begin pwm_o = 1'b1;     pwm_n_o = 1'b0;     end
            MODE_DIRECT: begin pwm_o = wired_or; pwm_n_o = inv_q;    end
            MODE_INVERT: begin pwm_o = inv_q;    pwm_n_o = wired_or; end
            default:     begin pwm_o = 1'b0;     pwm_n_o = 1'b1;     end
        endcase
    end

endmodule

// File: rtl/ovl_pwm_gen.sv
// Top level of the phase-overlap PWM generator: decoder, oscillator pair and
// output stage. Duty is set by the phase lead of one oscillator over the other.
// Assumes: ACC_W >= DUTY_W, DUTY_W >= 3.
module ovl_pwm_gen
    import ovl_pwm_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  freq_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o,
    output logic              pwm_n_o
);

    localparam int NCO_N = 2;

    logic             reload;
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] off;
    ovl_mode_e        mode;
    logic [NCO_N-1:0] msb;

    ovl_cfg #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_i   (freq_i),
        .duty_i   (duty_i),
        .reload_o (reload),
        .inc_o    (inc),
        .off_o    (off),
        .mode_o   (mode)
    );

    ovl_nco_pair #(.ACC_W(ACC_W), .NCO_N(NCO_N)) u_nco (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (inc),
        .load_i (reload),
        .off_i  (off),
        .msb_o  (msb)
    );

    ovl_combine #(.NCO_N(NCO_N)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .msb_i   (msb),
        .mode_i  (mode),
        .pwm_o   (pwm_o),
        .pwm_n_o (pwm_n_o)
    );

endmodule

// File: rtl/ovl_pwm_chk.sv
// Property checker for ovl_pwm_gen, attached by bind below.
// Assumes: reset is asserted from time zero.
module ovl_pwm_chk
    import ovl_pwm_pkg::*;
#(
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DUTY_W-1:0] duty_i,
    input logic              pwm_o,
    input logic              pwm_n_o,
    input ovl_mode_e         mode
);

    localparam int FULL = 1 << (DUTY_W - 1);

    // R1: outputs idle right after reset
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pwm_o && pwm_n_o));

    // R5: zero duty held for two cycles gives a steady low
    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && duty_i == '0 && $past(duty_i) == '0) |-> (!pwm_o && pwm_n_o));

    // R6: full-scale duty held for two cycles gives a steady high
    a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && duty_i >= DUTY_W'(FULL) && $past(duty_i) >= DUTY_W'(FULL))
        |-> (pwm_o && !pwm_n_o));

    // R7: complement pin follows the main pin inverted one cycle later
    a_r7_comp_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIRECT && $past(mode) == MODE_DIRECT) |-> (pwm_n_o == !$past(pwm_o)));

    // R8: below 50% the main pin is the delayed inverse of the complement pin
    a_r8_swap_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INVERT && $past(mode) == MODE_INVERT) |-> (pwm_o == !$past(pwm_n_o)));

    // R5 / R6: the two pins never sit at the same level in a steady mode
    a_r6_pins_differ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HIGH || mode == MODE_LOW) |-> (pwm_o != pwm_n_o));

endmodule

bind ovl_pwm_gen ovl_pwm_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .duty_i  (duty_i),
    .pwm_o   (pwm_o),
    .pwm_n_o (pwm_n_o),
    .mode    (mode)
);

// File: tb/ovl_pwm_gen_test.sv
// Directed bench for ovl_pwm_gen, built with ACC_W = 8 and DUTY_W = 5.
module ovl_pwm_gen_test;

    localparam int ACC_W  = 8;
    localparam int DUTY_W = 5;
    localparam int FULL   = 1 << (DUTY_W - 1);
    localparam int SPAN   = 1 << ACC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ACC_W-1:0]  freq = '0;
    logic [DUTY_W-1:0] duty = '0;
    logic              pwm_o;
    logic              pwm_n_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    ovl_pwm_gen #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .freq_i  (freq),
        .duty_i  (duty),
        .pwm_o   (pwm_o),
        .pwm_n_o (pwm_n_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply new commands on a falling edge and wait two full periods
    task automatic program_cfg(input int f, input int d);
        @(negedge clk);
        freq = ACC_W'(f);
        duty = DUTY_W'(d);
        repeat (2 * SPAN / f + 8) @(negedge clk);
    endtask

    task automatic count_high(input int len, output int hi, output int lo_n);
        hi = 0;
        lo_n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_o)    hi++;
            if (!pwm_n_o) lo_n++;
        end
    endtask

    task automatic measure_period(output int per);
        logic prev;
        int   guard;
        prev  = pwm_o;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
            if (pwm_o && !prev) break;
            prev = pwm_o;
        end while (guard < 2 * SPAN);
        per  = 0;
        prev = pwm_o;
        do begin
            @(negedge clk);
            per++;
            if (pwm_o && !prev) break;
            prev = pwm_o;
        end while (per < 2 * SPAN);
    endtask

    task automatic t_reset;
        @(negedge clk);
        freq = 8'd1;
        duty = 5'd12;
        repeat (3) @(negedge clk);
        check("R1 pwm_o in reset", int'(pwm_o), 0);
        check("R1 pwm_n_o in reset", int'(pwm_n_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pwm_o after release", int'(pwm_o), 0);
        check("R1 pwm_n_o after release", int'(pwm_n_o), 1);
    endtask

    task automatic t_period;
        int per;
        program_cfg(1, 12);
        measure_period(per);
        check("R2 period freq=1", per, 256);
        program_cfg(4, 12);
        measure_period(per);
        check("R2 period freq=4", per, 64);
    endtask

    task automatic t_direct;
        int hi, lo_n;
        program_cfg(1, 12);
        count_high(256, hi, lo_n);
        check("R3 high count D=12 P=256", hi, 12 * 256 / FULL);
        program_cfg(2, 15);
        count_high(128, hi, lo_n);
        check("R3 high count D=15 P=128", hi, 15 * 128 / FULL);
    endtask

    task automatic t_half;
        int hi, lo_n, per;
        program_cfg(1, 8);
        count_high(256, hi, lo_n);
        check("R10 high count D=8", hi, 128);
        measure_period(per);
        check("R10 period D=8", per, 256);
    endtask

    task automatic t_inverted;
        int hi, lo_n;
        program_cfg(1, 3);
        count_high(256, hi, lo_n);
        check("R4 high count D=3 P=256", hi, 3 * 256 / FULL);
        program_cfg(4, 1);
        count_high(64, hi, lo_n);
        check("R4 high count D=1 P=64", hi, 1 * 64 / FULL);
    endtask

    task automatic t_force_low;
        int hi, lo_n;
        program_cfg(1, 0);
        count_high(300, hi, lo_n);
        check("R5 pwm_o high cycles D=0", hi, 0);
        check("R5 pwm_n_o low cycles D=0", lo_n, 0);
    endtask

    task automatic t_force_high;
        int hi, lo_n;
        program_cfg(1, 16);
        count_high(300, hi, lo_n);
        check("R6 pwm_o high cycles D=16", hi, 300);
        check("R6 pwm_n_o low cycles D=16", lo_n, 300);
        program_cfg(2, 31);
        count_high(300, hi, lo_n);
        check("R6 pwm_o high cycles D=31", hi, 300);
    endtask

    task automatic t_comp(input int d, input bit swapped, input string req);
        logic prev;
        int   bad;
        program_cfg(1, d);
        bad  = 0;
        prev = swapped ? pwm_n_o : pwm_o;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (swapped) begin
                if (pwm_o != !prev) bad++;
                prev = pwm_n_o;
            end else begin
                if (pwm_n_o != !prev) bad++;
                prev = pwm_o;
            end
        end
        check(req, bad, 0);
    endtask

    task automatic t_freq_indep;
        int per_a, per_b;
        program_cfg(2, 13);
        measure_period(per_a);
        program_cfg(2, 5);
        measure_period(per_b);
        check("R9 period D=13", per_a, 128);
        check("R9 period D=5", per_b, 128);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_period();
        t_direct();
        t_half();
        t_inverted();
        t_force_low();
        t_force_high();
        t_comp(12, 1'b0, "R7 complement lag mismatches D=12");
        t_comp(3, 1'b1, "R8 swapped lag mismatches D=3");
        t_freq_indep();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule